// File: doc/BRIEF.md
# Ratio Measurement Switch Sequencer

This controller runs one ratio measurement in a voltmeter front end as three conversions back to back. The first measures the input signal, as DC, AC or AC+DC volts. The second measures the high side of the reference and the third measures its low side. For each conversion it sets the range relays and the analog path switches, forces autozero on or off, lets the switches settle and strobes the converter. It then waits for the converter's done input and keeps the reading. The three raw readings leave through a valid/ready output. The ratio arithmetic and any correction are done downstream.

Between two conversions, every analog path switch opens for a break interval of `BREAK_CYC` cycles before the next set closes. A settle interval of `SETTLE_CYC` cycles follows before the conversion strobe. The range relay chosen for a DC signal stays closed through all three conversions. The result interface applies back-pressure: once `res_valid` rises, the three readings stay frozen and the block accepts no new start until `res_ready` is seen high. An unusable function or range code aborts the request at once. A remote request to run without autozero is flagged and not honoured.

Top module: `ratio_seq`

## Requirements
- R1: A `start` pulse seen while idle with valid codes begins a measurement, and `busy` is high from the next cycle. A `start` seen while busy, including while results wait to be taken, has no effect.
- R2: Exactly three `conv_start` pulses, each one cycle long, are issued per measurement. The readings taken at the three `conv_done` cycles appear in order on `res_sig`, `res_ref_hi` and `res_ref_lo`.
- R3: `autozero_en` is high from the first break through the signal conversion and low throughout both reference conversions.
- R4: If `remote` and `az_off_req` are both high at start, `err_az` is set until the next accepted start and autozero is still enabled for the signal conversion. In local operation `az_off_req` is ignored.
- R5: `ratio_fn` encoding: 0 = DC, 1 = AC, 2 = AC+DC. `range_sel` encoding: 0 = 0.1 V, 1 = 1 V, 2 = 10 V, 3 = 100 V, 4 = 1000 V. For DC, ranges 3–4 close relay `sw_ctl[1]` with path `sw_ctl[3]`, and ranges 0–2 close relay `sw_ctl[0]` with path `sw_ctl[2]`.
- R6: For DC, the selected range relay stays closed through all three conversions and their breaks, while its path switch is open in both reference conversions.
- R7: For AC and AC+DC, only path switch `sw_ctl[4]` is closed in the signal conversion, and no range relay is used.
- R8: The reference-high conversion closes `sw_ctl[5]` (reference sense high) and `sw_ctl[6]` (measure low). The reference-low conversion closes only `sw_ctl[7]` (ground reference) apart from any range relay.
- R9: Starting from the start cycle or the `conv_done` cycle, `sw_ctl` holds only relay bits for `BREAK_CYC` cycles. The new switch set then holds for `SETTLE_CYC` cycles, and `conv_start` pulses in the next cycle.
- R10: After the third reading, `res_valid` stays high with stable readings, all switches open and autozero off, until a cycle with `res_ready` high. The block is idle in the cycle after.
- R11: A start with `ratio_fn` = 3 or `range_sel` > 4 sets `err_cfg`, leaves the block idle with all switches open and issues no conversion. The next accepted start clears `err_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a measurement |
| ratio_fn | input | 2 | Ratio function code, sampled at start |
| range_sel | input | 3 | Range code, sampled at start |
| remote | input | 1 | High when under remote control |
| az_off_req | input | 1 | Remote request to disable autozero |
| conv_done | input | 1 | Converter finished, `conv_data` valid |
| conv_data | input | DW | Raw converter reading |
| res_ready | input | 1 | Downstream accepts the readings |
| sw_ctl | output | 8 | Relay and switch closures, one bit each |
| autozero_en | output | 1 | Autozero enable for the converter |
| conv_start | output | 1 | One-cycle conversion strobe |
| busy | output | 1 | Measurement in progress or results pending |
| err_cfg | output | 1 | Last start had an invalid code |
| err_az | output | 1 | Remote autozero-off request refused |
| res_valid | output | 1 | Three readings available |
| res_sig | output | DW | Signal reading |
| res_ref_hi | output | DW | Reference-high reading |
| res_ref_lo | output | DW | Reference-low reading |

## Verification
A wrong phase or state shows up on `sw_ctl` within the same cycle, because the switch pattern is decoded directly from state. A skipped or repeated phase moves the `conv_start` pulse away from its expected cycle. A wrong count in the break or settle interval shifts that pulse by one or more cycles, which the bench sees at the first conversion. A reading latched into the wrong slot stays hidden until `res_valid` rises at the end of the measurement.

// File: rtl/ratio_seq_pkg.sv
package ratio_seq_pkg;
  localparam int SW_W       = 8;
  localparam int SW_RLY_LO  = 0;
  localparam int SW_RLY_HI  = 1;
  localparam int SW_PATH_LO = 2;
  localparam int SW_PATH_HI = 3;
  localparam int SW_PATH_AC = 4;
  localparam int SW_REF_HI  = 5;
  localparam int SW_MEAS_LO = 6;
  localparam int SW_GND_REF = 7;

  localparam logic [1:0] FN_DC   = 2'd0;
  localparam logic [1:0] FN_AC   = 2'd1;
  localparam logic [1:0] FN_ACDC = 2'd2;
  localparam logic [2:0] RNG_MAX     = 3'd4;
  localparam logic [2:0] RNG_HI_MIN  = 3'd3;
  localparam int N_PHASE = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BREAK, ST_SETTLE, ST_LAUNCH, ST_WAIT, ST_HOLD
  } state_e;

  typedef enum logic [1:0] {PH_SIG = 2'd0, PH_RHI = 2'd1, PH_RLO = 2'd2} phase_e;
endpackage

// File: rtl/ratio_seq_ctrl.sv
module ratio_seq_ctrl
  import ratio_seq_pkg::*;
#(
  parameter int BREAK_CYC  = 2,
  parameter int SETTLE_CYC = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   cfg_ok,
  input  logic   az_refuse,
  input  logic   conv_done,
  input  logic   res_ready,
  output state_e state,
  output phase_e phase,
  output logic   accept,
  output logic   conv_start,
  output logic   capture,
  output logic   res_valid,
  output logic   err_cfg,
  output logic   err_az
);
  localparam int MAXC  = (BREAK_CYC > SETTLE_CYC) ? BREAK_CYC : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  state_e           nxt;
  logic             reject;

  assign accept     = (state == ST_IDLE) && start && cfg_ok;
  assign reject     = (state == ST_IDLE) && start && !cfg_ok;
  assign conv_start = (state == ST_LAUNCH);
  assign capture    = (state == ST_WAIT) && conv_done;
  assign res_valid  = (state == ST_HOLD);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (accept) nxt = ST_BREAK;
      ST_BREAK:  if (cnt == CNT_W'(BREAK_CYC - 1)) nxt = ST_SETTLE;
      ST_SETTLE: if (cnt == CNT_W'(SETTLE_CYC - 1)) nxt = ST_LAUNCH;
      ST_LAUNCH: nxt = ST_WAIT;
      ST_WAIT:   if (conv_done) nxt = (phase == PH_RLO) ? ST_HOLD : ST_BREAK;
      ST_HOLD:   if (res_ready) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      phase   <= PH_SIG;
      err_cfg <= 1'b0;
      err_az  <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      if (accept) begin
        phase   <= PH_SIG;
        err_cfg <= 1'b0;
        err_az  <= az_refuse;
      end else if (capture && phase != PH_RLO) begin
        phase <= phase_e'(phase + 2'd1);
      end
      if (reject) err_cfg <= 1'b1;
    end
  end
endmodule

// File: rtl/ratio_seq_switch.sv
module ratio_seq_switch
  import ratio_seq_pkg::*;
(
  input  state_e          state,
  input  phase_e          phase,
  input  logic [1:0]      fn,
  input  logic [2:0]      rng,
  output logic [SW_W-1:0] sw
);
  logic dc, hi, active, closed;

  assign dc     = (fn == FN_DC);
  assign hi     = (rng >= RNG_HI_MIN);
  assign active = (state != ST_IDLE) && (state != ST_HOLD);
  assign closed = (state == ST_SETTLE) || (state == ST_LAUNCH) || (state == ST_WAIT);

  always_comb begin
    sw = '0;
    if (active && dc) begin
      if (hi) sw[SW_RLY_HI] = 1'b1;
      else    sw[SW_RLY_LO] = 1'b1;
    end
    if (closed) begin
      case (phase)
        PH_SIG: begin
          if (!dc)     sw[SW_PATH_AC] = 1'b1;
          else if (hi) sw[SW_PATH_HI] = 1'b1;
          else         sw[SW_PATH_LO] = 1'b1;
        end
        PH_RHI: begin
          sw[SW_REF_HI]  = 1'b1;
          sw[SW_MEAS_LO] = 1'b1;
        end
        PH_RLO:  sw[SW_GND_REF] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ratio_seq_capture.sv
module ratio_seq_capture
  import ratio_seq_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  phase_e                     phase,
  input  logic [DW-1:0]              data,
  output logic [N_PHASE-1:0][DW-1:0] rd
);
  for (genvar g = 0; g < N_PHASE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 rd[g] <= '0;
      else if (capture && phase == phase_e'(g))   rd[g] <= data;
    end
  end
endmodule

// File: rtl/ratio_seq.sv
module ratio_seq
  import ratio_seq_pkg::*;
#(
  parameter int DW         = 24,
  parameter int BREAK_CYC  = 2,
  parameter int SETTLE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      ratio_fn,
  input  logic [2:0]      range_sel,
  input  logic            remote,
  input  logic            az_off_req,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  input  logic            res_ready,
  output logic [SW_W-1:0] sw_ctl,
  output logic            autozero_en,
  output logic            conv_start,
  output logic            busy,
  output logic            err_cfg,
  output logic            err_az,
  output logic            res_valid,
  output logic [DW-1:0]   res_sig,
  output logic [DW-1:0]   res_ref_hi,
  output logic [DW-1:0]   res_ref_lo
);
  state_e                     state;
  phase_e                     phase;
  logic                       accept, capture, cfg_ok;
  logic [1:0]                 fn_q;
  logic [2:0]                 rng_q;
  logic [N_PHASE-1:0][DW-1:0] rd;

  assign cfg_ok = (ratio_fn != 2'd3) && (range_sel <= RNG_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= FN_DC;
      rng_q <= '0;
    end else if (accept) begin
      fn_q  <= ratio_fn;
      rng_q <= range_sel;
    end
  end

  ratio_seq_ctrl #(.BREAK_CYC(BREAK_CYC), .SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk, .rst_n, .start, .cfg_ok,
    .az_refuse (remote && az_off_req),
    .conv_done, .res_ready,
    .state, .phase, .accept, .conv_start, .capture, .res_valid, .err_cfg, .err_az
  );

  ratio_seq_switch sw_i (
    .state, .phase, .fn(fn_q), .rng(rng_q), .sw(sw_ctl)
  );

  ratio_seq_capture #(.DW(DW)) cap_i (
    .clk, .rst_n, .capture, .phase, .data(conv_data), .rd
  );

  assign busy        = (state != ST_IDLE);
  assign autozero_en = busy && !res_valid && (phase == PH_SIG);
  assign res_sig     = rd[PH_SIG];
  assign res_ref_hi  = rd[PH_RHI];
  assign res_ref_lo  = rd[PH_RLO];
endmodule

// File: rtl/ratio_seq_chk.sv
module ratio_seq_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    sw_ctl,
  input logic          autozero_en,
  input logic          conv_start,
  input logic          busy,
  input logic          err_cfg,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_sig,
  input logic [DW-1:0] res_ref_hi,
  input logic [DW-1:0] res_ref_lo
);
  assert_relay_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_ctl[1:0]));

  assert_path_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_ctl[2] | sw_ctl[3] | sw_ctl[4], sw_ctl[5], sw_ctl[7]}));

  assert_ref_no_az_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ctl[5] || sw_ctl[7]) |-> !autozero_en);

  assert_settled_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($stable(sw_ctl) && sw_ctl[7:2] != 6'd0));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_relay_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !res_valid && $past(busy && !res_valid)) |-> $stable(sw_ctl[1:0]));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_sig) && $stable(res_ref_hi) && $stable(res_ref_lo)));

  assert_result_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (sw_ctl == 8'd0 && !autozero_en));

  assert_cfg_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_cfg |-> (!busy && sw_ctl == 8'd0));
endmodule

bind ratio_seq ratio_seq_chk #(.DW(DW)) chk_i (.*);

// File: tb/ratio_seq_tb_top.sv
`timescale 1ns/1ps
module ratio_seq_tb_top;
  localparam int DW = 24;
  localparam int BRK = 2;
  localparam int STL = 3;
  localparam int GAP = BRK + STL + 1;

  typedef struct packed {
    logic [1:0] fn;
    logic [2:0] rng;
    logic       rmt;
    logic       azo;
    logic [7:0] sw0;
    logic       erraz;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 3'd0, 1'b0, 1'b1, 8'h05, 1'b0},
    '{2'd0, 3'd2, 1'b1, 1'b0, 8'h05, 1'b0},
    '{2'd0, 3'd3, 1'b1, 1'b1, 8'h0A, 1'b1},
    '{2'd0, 3'd4, 1'b0, 1'b0, 8'h0A, 1'b0},
    '{2'd1, 3'd1, 1'b1, 1'b1, 8'h10, 1'b1},
    '{2'd2, 3'd4, 1'b0, 1'b0, 8'h10, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, remote = 1'b0, az_off_req = 1'b0, conv_done = 1'b0, res_ready = 1'b0;
  logic [1:0] ratio_fn = '0;
  logic [2:0] range_sel = '0;
  logic [DW-1:0] conv_data = '0;
  logic [7:0] sw_ctl;
  logic autozero_en, conv_start, busy, err_cfg, err_az, res_valid;
  logic [DW-1:0] res_sig, res_ref_hi, res_ref_lo;

  int checks = 0, failures = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  ratio_seq #(.DW(DW), .BREAK_CYC(BRK), .SETTLE_CYC(STL)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rdval(int vi, int ph);
    return {8'(vi + 1), 8'(ph), 8'hA5};
  endfunction

  task automatic run_meas(input int vi, input vec_t v, input int hold);
    logic [7:0] rly, exp_sw;
    int n;
    rly = v.sw0 & 8'h03;
    @(negedge clk);
    ratio_fn = v.fn; range_sel = v.rng; remote = v.rmt; az_off_req = v.azo; start = 1'b1;
    for (int ph = 0; ph < 3; ph++) begin
      n = 0;
      do begin
        @(negedge clk);
        start = 1'b0; conv_done = 1'b0;
        n++;
        if (n == 1) begin
          chk(busy == 1'b1, "R1 busy", busy, 1);
          chk(sw_ctl == rly, "R9 break pattern", sw_ctl, rly);
          if (ph == 0) begin
            chk(err_az == v.erraz, "R4 err_az", err_az, v.erraz);
            chk(err_cfg == 1'b0, "R11 err_cfg cleared", err_cfg, 0);
          end
        end
      end while (!conv_start && n < 100);
      chk(n == GAP, "R9 strobe timing", n, GAP);
      exp_sw = (ph == 0) ? v.sw0 : (ph == 1) ? (rly | 8'h60) : (rly | 8'h80);
      chk(sw_ctl == exp_sw, (ph == 0) ? "R5 R7 signal switches" : "R6 R8 reference switches",
          sw_ctl, exp_sw);
      chk(autozero_en == (ph == 0), "R3 autozero", autozero_en, ph == 0);
      @(negedge clk);
      conv_done = 1'b1; conv_data = rdval(vi, ph);
      if (ph == 1) start = 1'b1;
    end
    @(negedge clk);
    conv_done = 1'b0; start = 1'b0;
    chk(res_valid == 1'b1, "R10 res_valid", res_valid, 1);
    chk(sw_ctl == 8'd0 && !autozero_en, "R10 open on hold", sw_ctl, 0);
    chk(res_sig == rdval(vi, 0), "R2 signal reading", res_sig, rdval(vi, 0));
    chk(res_ref_hi == rdval(vi, 1), "R2 ref high reading", res_ref_hi, rdval(vi, 1));
    chk(res_ref_lo == rdval(vi, 2), "R2 ref low reading", res_ref_lo, rdval(vi, 2));
    for (int h = 0; h < hold; h++) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(res_valid && !conv_start && res_sig == rdval(vi, 0), "R10 back-pressure hold", res_valid, 1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!busy && !res_valid && sw_ctl == 8'd0, "R10 idle after accept", busy, 0);
  endtask

  task automatic bad_start(input logic [1:0] f, input logic [2:0] r, input string tag);
    bit seen;
    @(negedge clk);
    ratio_fn = f; range_sel = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_cfg == 1'b1, tag, err_cfg, 1);
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (busy || conv_start || sw_ctl != 8'd0) seen = 1'b1;
    end
    chk(!seen, "R11 stays idle", seen, 0);
  endtask

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sw_ctl == 8'd0 && !busy && !res_valid && !conv_start && !autozero_en && !err_cfg && !err_az,
        "R1 reset state", sw_ctl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) run_meas(i, VECS[i], (i == 2) ? 4 : 0);
    bad_start(2'd3, 3'd1, "R11 bad function");
    bad_start(2'd0, 3'd7, "R11 bad range");
    run_meas(6, VECS[3], 1);
    @(negedge clk);
    remote = 1'b0; az_off_req = 1'b1;
    chk(err_az == 1'b0, "R4 local ignores request", err_az, 0);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule